// File: doc/BRIEF.md
# Converter Bring-up Register Sequencer

This block programs a high-speed data converter after power-up or after a change of operating mode. Three static selections choose the configuration: the output lane arrangement (two lanes, one lane or half a lane per channel), the output sample width (14, 16, 18 or 20 bit) and whether the on-chip digital path runs in complex decimation or in bypass/real decimation. After a start pulse the block derives the byte for every register it must touch. It then issues those writes one at a time on a simple address/data request port with a valid/ready handshake. A serial bus engine downstream turns each write into real bus traffic.

The lane-mode write goes out first, followed by the fuse-reload pulse. The reload bit is set, the block idles for a fixed delay of about one millisecond counted in clock cycles, and then the bit is cleared. The frame-clock control, width code, frame-clock pattern, IQ ordering and the gain/NCO-reset writes follow. The block raises `done` after the last write is accepted. A selection that has no valid setting raises `cfg_err` and produces no bus traffic.

Top module: `adc_cfg_seq`

## Requirements
- R1: After reset, `wr_valid`, `busy`, `done` and `cfg_err` are all low.
- R2: The first write goes to address 0x07. Encodings: `iface_sel` 0 is two-lane, 1 is one-lane, 2 is half-lane and 3 is reserved; `res_sel` 0/1/2/3 means 14/16/18/20 bit. The data byte is 0x2B, 0x4B, 0x2B or 0x4B for two-lane at 14/16/18/20 bit, 0x6C for one-lane at 14 bit and 0x8D for half-lane at 14 bit.
- R3: The second write is 0x01 to address 0x13. Exactly WAIT_CYC = CLK_FREQ_HZ/1000 cycles with `wr_valid` low follow its acceptance, and then 0x00 is written to 0x13.
- R4: The remaining writes follow in this address order: 0x19, 0x1B, 0x20, 0x21, 0x22, 0x27, 0x2E, 0x26, 0x26. That makes twelve writes in all.
- R5: Address 0x19 receives source in bit 2, divide in bit 1 and toggle in bit 0, with all other bits zero. In bypass mode these bits are 0,1,0 for two-lane and 0,0,0 otherwise. In complex mode they are 1,0,0 for two-lane and one-lane, and 0,0,1 for half-lane.
- R6: Address 0x1B receives the width code `res_sel` in bits 1:0, with all other bits zero.
- R7: A 20-bit frame pattern is written low byte first: bits 7:0 to 0x20, bits 15:8 to 0x21 and bits 19:16 to 0x22 bits 3:0. The pattern is 0xFFFFF in complex mode. In bypass mode it is 0xFFC00/0xFF000/0xFF800/0xFFC00 for two-lane at 14/16/18/20 bit, 0xFE000 for one-lane and 0xFFC00 for half-lane.
- R8: In complex mode, bit 0 of 0x27 (IQ order) and bit 0 of 0x2E (Q delay) are 1,0 for two-lane, 0,1 for one-lane and 1,1 for half-lane. In bypass mode both are 0. All other bits of both bytes are zero.
- R9: Address 0x26 is written twice. Each time, bits 7:1 carry GAIN_CODE. Bit 0 (NCO reset) is 1 in the first write and 0 in the second.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R11: A `start` pulse while `busy` is high is ignored. The sequence continues unchanged and uses the selection latched at its own start.
- R12: `busy` is high from the cycle after an accepted start until the cycle after the last write is accepted. `done` rises in that same cycle and stays high until the next `start`.
- R13: A start with a reserved lane mode, or with one-lane or half-lane at a width other than 14 bit, sets `cfg_err`, leaves `busy` low and issues no write. `cfg_err` stays set until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to run the sequence |
| iface_sel | input | 2 | Lane arrangement select |
| res_sel | input | 2 | Output width select |
| dsp_cplx | input | 1 | 1 = complex decimation, 0 = bypass/real decimation |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Downstream accepts the write this cycle |
| wr_addr | output | 8 | Register address |
| wr_data | output | 8 | Register data byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| cfg_err | output | 1 | Last start carried an illegal selection |

## Verification
`busy` and the first request appear one clock edge after `start` is sampled. `cfg_err` after an illegal start also appears one edge later. The bench drives and samples on the falling edge, so each of these is checked at the next falling edge. The next request, or `done`, is visible at the falling edge following the one where `wr_ready` was raised. The fuse gap is measured by counting the falling edges with `wr_valid` low between the two fuse writes, and the bench expects exactly WAIT_CYC of them. Stalls of two cycles are checked at each falling edge while `wr_ready` is held low.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

  localparam int unsigned REG_AW   = 8;
  localparam int unsigned REG_DW   = 8;
  localparam int unsigned NUM_WR   = 12;
  localparam int unsigned FUSE_IDX = 1;
  localparam int unsigned PAT_W    = 20;

  typedef enum logic [1:0] {
    IFM_TWO  = 2'd0,
    IFM_ONE  = 2'd1,
    IFM_HALF = 2'd2,
    IFM_RSVD = 2'd3
  } ifm_t;

  typedef enum logic [1:0] {
    RES_14 = 2'd0,
    RES_16 = 2'd1,
    RES_18 = 2'd2,
    RES_20 = 2'd3
  } res_t;

  typedef struct packed {
    ifm_t ifm;
    res_t res;
    logic cplx;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_PAUSE = 2'd2
  } st_t;

  // Only two-lane supports every width; the narrower lane modes are 14-bit only.
  function automatic logic cfg_legal(cfg_t c);
    case (c.ifm)
      IFM_TWO:  return 1'b1;
      IFM_ONE,
      IFM_HALF: return (c.res == RES_14);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/adc_cfg_timer.sv
module adc_cfg_timer #(
  parameter int unsigned CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (run && (cnt_q != '0));
    cnt_d  = load ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R3: once loaded and running, the count only moves downward until zero.
  p_timer_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !expired) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/adc_cfg_lut.sv
module adc_cfg_lut
  import adc_cfg_pkg::*;
#(
  parameter logic [6:0]  GAIN_CODE = 7'h00,
  parameter int unsigned STEP_W    = 4
) (
  input  cfg_t                cfg,
  input  logic [STEP_W-1:0]   step,
  output logic [REG_AW-1:0]   addr,
  output logic [REG_DW-1:0]   data
);
  logic [REG_DW-1:0] lane_byte;
  logic [PAT_W-1:0]  pattern;
  logic              fc_src, fc_div, fc_tog;
  logic              iq_ord, q_del;

  // Lane-mode byte for the first write.
  always_comb begin
    lane_byte = 8'h00;
    case (cfg.ifm)
      IFM_TWO:  lane_byte = (cfg.res == RES_16 || cfg.res == RES_20) ? 8'h4B : 8'h2B;
      IFM_ONE:  lane_byte = 8'h6C;
      IFM_HALF: lane_byte = 8'h8D;
      default:  lane_byte = 8'h00;
    endcase
  end

  // Frame-clock pattern: saturated in complex mode, width/lane dependent otherwise.
  always_comb begin
    pattern = 20'hFFFFF;
    if (!cfg.cplx) begin
      case (cfg.ifm)
        IFM_ONE:  pattern = 20'hFE000;
        IFM_HALF: pattern = 20'hFFC00;
        default: begin
          case (cfg.res)
            RES_16:  pattern = 20'hFF000;
            RES_18:  pattern = 20'hFF800;
            default: pattern = 20'hFFC00;
          endcase
        end
      endcase
    end
  end

  // Frame-clock control and IQ ordering bits.
  always_comb begin
    fc_src = cfg.cplx && (cfg.ifm != IFM_HALF);
    fc_div = !cfg.cplx && (cfg.ifm == IFM_TWO);
    fc_tog = cfg.cplx && (cfg.ifm == IFM_HALF);
    iq_ord = cfg.cplx && (cfg.ifm != IFM_ONE);
    q_del  = cfg.cplx && (cfg.ifm != IFM_TWO);
  end

  always_comb begin
    addr = 8'h00;
    data = 8'h00;
    case (step)
      STEP_W'(0):  begin addr = 8'h07; data = lane_byte; end
      STEP_W'(1):  begin addr = 8'h13; data = 8'h01; end
      STEP_W'(2):  begin addr = 8'h13; data = 8'h00; end
      STEP_W'(3):  begin addr = 8'h19; data = {5'b0, fc_src, fc_div, fc_tog}; end
      STEP_W'(4):  begin addr = 8'h1B; data = {6'b0, cfg.res}; end
      STEP_W'(5):  begin addr = 8'h20; data = pattern[7:0]; end
      STEP_W'(6):  begin addr = 8'h21; data = pattern[15:8]; end
      STEP_W'(7):  begin addr = 8'h22; data = {4'b0, pattern[19:16]}; end
      STEP_W'(8):  begin addr = 8'h27; data = {7'b0, iq_ord}; end
      STEP_W'(9):  begin addr = 8'h2E; data = {7'b0, q_del}; end
      STEP_W'(10): begin addr = 8'h26; data = {GAIN_CODE, 1'b1}; end
      STEP_W'(11): begin addr = 8'h26; data = {GAIN_CODE, 1'b0}; end
      default:     begin addr = 8'h00; data = 8'h00; end
    endcase
  end

endmodule

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
  import adc_cfg_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter logic [6:0]  GAIN_CODE   = 7'h00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          iface_sel,
  input  logic [1:0]          res_sel,
  input  logic                dsp_cplx,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [REG_AW-1:0]   wr_addr,
  output logic [REG_DW-1:0]   wr_data,
  output logic                busy,
  output logic                done,
  output logic                cfg_err
);
  localparam int unsigned WAIT_CYC = (CLK_FREQ_HZ / 1000 > 0) ? CLK_FREQ_HZ / 1000 : 1;
  localparam int unsigned STEP_W   = $clog2(NUM_WR);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_WR - 1);
  localparam logic [STEP_W-1:0] FUSE_STEP = STEP_W'(FUSE_IDX);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  st_t               st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  cfg_t              cfg_q, cfg_d, cfg_in;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              tmr_load, tmr_exp, tmr_run;

  assign cfg_in = '{ifm: ifm_t'(iface_sel), res: res_t'(res_sel), cplx: dsp_cplx};

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    cfg_d    = cfg_q;
    done_d   = done_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          done_d = 1'b0;
          if (cfg_legal(cfg_in)) begin
            cfg_d  = cfg_in;
            err_d  = 1'b0;
            step_d = '0;
            st_d   = ST_WRITE;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (wr_ready) begin
          if (step_q == LAST_STEP) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            step_d = '0;
          end else begin
            step_d = step_q + 1'b1;
            if (step_q == FUSE_STEP) begin
              st_d     = ST_PAUSE;
              tmr_load = 1'b1;
            end
          end
        end
      end
      ST_PAUSE: begin
        if (tmr_exp) st_d = ST_WRITE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      cfg_q  <= '{ifm: IFM_TWO, res: RES_14, cplx: 1'b0};
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      cfg_q  <= cfg_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign tmr_run = (st_q == ST_PAUSE);

  adc_cfg_timer #(.CYC(WAIT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .load    (tmr_load),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  adc_cfg_lut #(.GAIN_CODE(GAIN_CODE), .STEP_W(STEP_W)) u_lut (
    .cfg  (cfg_q),
    .step (step_q),
    .addr (wr_addr),
    .data (wr_data)
  );

  assign wr_valid = (st_q == ST_WRITE);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign cfg_err  = err_q;

  // R10: a stalled request keeps its contents.
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R2: a new sequence opens with the lane-mode register.
  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(busy) |-> (wr_valid && wr_addr == 8'h07));

  // R3: acceptance of the reload-set write is followed by a quiet cycle.
  p_fuse_gap_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_valid && wr_ready && wr_addr == 8'h13 && wr_data == 8'h01) |=> !wr_valid);

  // R13: an error flag never coexists with bus traffic.
  p_err_quiet_r13: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_err |-> (!wr_valid && !busy));

  // R12: done is only shown while idle.
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |-> !busy);

  // R11: start during a run does not end the run unless the last write is taken.
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && start && !(wr_valid && wr_ready)) |=> busy);

endmodule

// File: tb/test_adc_cfg_seq.sv
module test_adc_cfg_seq;

  localparam int unsigned FREQ = 20000;
  localparam int unsigned WAIT = FREQ / 1000;
  localparam logic [6:0]  GAIN = 7'h15;

  // {iface[1:0], res[1:0], cplx, lane byte[7:0], pattern[19:0]}
  localparam logic [32:0] VEC [0:9] = '{
    {2'd0, 2'd0, 1'b0, 8'h2B, 20'hFFC00},
    {2'd0, 2'd1, 1'b0, 8'h4B, 20'hFF000},
    {2'd0, 2'd2, 1'b0, 8'h2B, 20'hFF800},
    {2'd0, 2'd3, 1'b0, 8'h4B, 20'hFFC00},
    {2'd1, 2'd0, 1'b0, 8'h6C, 20'hFE000},
    {2'd2, 2'd0, 1'b0, 8'h8D, 20'hFFC00},
    {2'd0, 2'd0, 1'b1, 8'h2B, 20'hFFFFF},
    {2'd1, 2'd0, 1'b1, 8'h6C, 20'hFFFFF},
    {2'd2, 2'd0, 1'b1, 8'h8D, 20'hFFFFF},
    {2'd0, 2'd3, 1'b1, 8'h4B, 20'hFFFFF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] iface_sel = 2'd0;
  logic [1:0] res_sel = 2'd0;
  logic       dsp_cplx = 1'b0;
  logic       wr_ready = 1'b0;
  logic       wr_valid, busy, done, cfg_err;
  logic [7:0] wr_addr, wr_data;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  adc_cfg_seq #(.CLK_FREQ_HZ(FREQ), .GAIN_CODE(GAIN)) i_adc_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .iface_sel(iface_sel),
    .res_sel(res_sel), .dsp_cplx(dsp_cplx), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic void exp_wr(input logic [32:0] v, input int s,
                                 output logic [7:0] a, output logic [7:0] d,
                                 output string tag);
    logic [1:0]  ifc  = v[32:31];
    logic [1:0]  res  = v[30:29];
    logic        cx   = v[28];
    logic [19:0] pat  = v[19:0];
    logic        src  = cx && ifc != 2'd2;
    logic        div  = !cx && ifc == 2'd0;
    logic        tog  = cx && ifc == 2'd2;
    case (s)
      0:  begin a = 8'h07; d = v[27:20];                tag = "R2"; end
      1:  begin a = 8'h13; d = 8'h01;                   tag = "R3"; end
      2:  begin a = 8'h13; d = 8'h00;                   tag = "R3"; end
      3:  begin a = 8'h19; d = {5'b0, src, div, tog};   tag = "R4 R5"; end
      4:  begin a = 8'h1B; d = {6'b0, res};             tag = "R4 R6"; end
      5:  begin a = 8'h20; d = pat[7:0];                tag = "R4 R7"; end
      6:  begin a = 8'h21; d = pat[15:8];               tag = "R4 R7"; end
      7:  begin a = 8'h22; d = {4'b0, pat[19:16]};      tag = "R4 R7"; end
      8:  begin a = 8'h27; d = {7'b0, cx && ifc != 2'd1}; tag = "R4 R8"; end
      9:  begin a = 8'h2E; d = {7'b0, cx && ifc != 2'd0}; tag = "R4 R8"; end
      10: begin a = 8'h26; d = {GAIN, 1'b1};            tag = "R4 R9"; end
      default: begin a = 8'h26; d = {GAIN, 1'b0};       tag = "R4 R9"; end
    endcase
  endfunction

  task automatic run_seq(input logic [32:0] v, input logic stall, input logic inject);
    logic [7:0] ea, ed;
    string      tag;
    iface_sel = v[32:31];
    res_sel   = v[30:29];
    dsp_cplx  = v[28];
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done && !cfg_err, "R12 start", {busy, done, cfg_err}, 3'b100);
    for (int s = 0; s < 12; s++) begin
      int gap = 0;
      while (!wr_valid && gap < WAIT + 50) begin
        @(negedge clk);
        gap++;
      end
      if (s == 2) check(gap == WAIT, "R3 gap", gap, WAIT);
      exp_wr(v, s, ea, ed, tag);
      if (stall && (s % 3 == 0)) begin
        logic [7:0] a0 = wr_addr;
        logic [7:0] d0 = wr_data;
        repeat (2) @(negedge clk);
        check(wr_valid && wr_addr == a0 && wr_data == d0, "R10 hold",
              {wr_valid, wr_addr, wr_data}, {1'b1, a0, d0});
      end
      if (inject && s == 5) begin
        start = 1'b1;
        iface_sel = 2'd3;
        @(negedge clk);
        start = 1'b0;
        check(busy && !cfg_err && wr_valid && wr_addr == 8'h20, "R11 ignore",
              {busy, cfg_err, wr_addr}, {2'b10, 8'h20});
      end
      check(wr_valid && wr_addr == ea, {tag, " addr"}, wr_addr, ea);
      check(wr_data == ed, {tag, " data"}, wr_data, ed);
      wr_ready = 1'b1;
      @(negedge clk);
      wr_ready = 1'b0;
    end
    check(done && !busy && !wr_valid, "R12 end", {done, busy, wr_valid}, 3'b100);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle outputs after reset.
    check(!wr_valid && !busy && !done && !cfg_err, "R1 reset",
          {wr_valid, busy, done, cfg_err}, 4'b0000);

    for (int i = 0; i < 10; i++) begin
      run_seq(VEC[i], (i % 2) == 1, i == 3);
    end

    // R12: done persists while idle.
    repeat (5) @(negedge clk);
    check(done && !busy, "R12 persist", {done, busy}, 2'b10);

    // R13: one-lane at 16 bit is illegal.
    iface_sel = 2'd1; res_sel = 2'd1; dsp_cplx = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_err && !busy && !wr_valid && !done, "R13 one-lane 16",
          {cfg_err, busy, wr_valid, done}, 4'b1000);
    begin
      int seen = 0;
      repeat (10) begin
        @(negedge clk);
        if (wr_valid || busy) seen++;
      end
      check(seen == 0 && cfg_err, "R13 quiet", seen, 0);
    end

    // R13: reserved lane mode.
    iface_sel = 2'd3; res_sel = 2'd0; dsp_cplx = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_err && !busy && !wr_valid, "R13 reserved", {cfg_err, busy, wr_valid}, 3'b100);

    // R13: half-lane at 18 bit is illegal.
    iface_sel = 2'd2; res_sel = 2'd2; dsp_cplx = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_err && !busy, "R13 half-lane 18", {cfg_err, busy}, 2'b10);

    // R13: a legal start clears the error and runs fully.
    run_seq(VEC[8], 1'b0, 1'b0);
    check(!cfg_err, "R13 cleared", cfg_err, 0);

    // R1: reset in the middle of a run returns to idle.
    iface_sel = 2'd0; res_sel = 2'd0; dsp_cplx = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!wr_valid && !busy && !done && !cfg_err, "R1 mid-run reset",
          {wr_valid, busy, done, cfg_err}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule